// File: doc/BRIEF.md
# Display Port Write Mirror

This block listens passively to a Z80 expansion-slot bus and keeps a copy of every I/O write that the CPU sends to the host video display processor. The processor occupies four consecutive I/O ports starting at 0x98. Each such write is captured together with its port offset and data byte. The entry is queued in a small FIFO, and a local video-processor model drains that FIFO through a valid/ready stream.

The mirror has no output toward the slot. It cannot answer a read, drive the data bus or request an interrupt, so the main-board display chip remains the only device the CPU sees. All slot inputs pass through a multi-flop synchroniser into a much faster local clock. At that rate, every bus write can be recorded long before the next one arrives.

Top module: `vdp_write_mirror`

## Requirements
- R1: After reset, out_valid is low and ovf_flag is low.
- R2: An I/O write to a port in 0x98..0x9B yields exactly one stream entry. A write is bus_iorq_n low, bus_m1_n high, bus_rd_n high and a falling bus_wr_n. In that entry, out_port equals bus_addr[1:0] and out_byte equals bus_data.
- R3: An I/O write to any port outside 0x98..0x9B yields no entry.
- R4: An I/O read (bus_rd_n low, bus_wr_n high) to any watched port yields no entry.
- R5: An interrupt-acknowledge cycle (bus_iorq_n low together with bus_m1_n low) never yields an entry, even if bus_wr_n falls during it.
- R6: A memory write (bus_iorq_n high, bus_wr_n falling) yields no entry, whatever the address.
- R7: Entries leave in capture order, and one leaves on each clock where out_valid and out_ready are both high. The queue holds 16 entries.
- R8: A write captured while 16 entries are queued is dropped and sets ovf_flag. The flag stays set until reset, and the 16 queued entries are unaffected.
- R9: Holding bus_wr_n low for many clocks produces only one entry per falling edge.
- R10: While out_valid is high and out_ready is low, out_valid, out_port and out_byte hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local fast clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Slot address bus, low byte |
| bus_data | input | 8 | Slot data bus (observed only) |
| bus_iorq_n | input | 1 | I/O request, active low |
| bus_wr_n | input | 1 | Write strobe, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_m1_n | input | 1 | Opcode fetch / acknowledge marker, active low |
| out_valid | output | 1 | Stream entry available |
| out_ready | input | 1 | Consumer accepts the entry |
| out_port | output | 2 | Port offset of the captured write |
| out_byte | output | 8 | Data byte of the captured write |
| ovf_flag | output | 1 | Sticky flag set when a write was dropped |

## Verification
The bench sweeps all 256 I/O addresses with writes, so an off-by-one or mis-masked port decode shows up as a missing or extra entry. It drives reads, memory writes and acknowledge cycles with the write strobe low. A decoder that checks only IORQ or ignores M1 would queue phantom writes there. A long-held strobe exposes a level-triggered capture, which would flood the queue with copies. Filling the queue past 16 entries and then draining it checks two things: that the overflowing write is dropped and not written over the oldest entry, and that the flag does not clear on its own.

// File: rtl/vdpm_pkg.sv
package vdpm_pkg;
    localparam int OFS_W  = 2;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 8;

    typedef struct packed {
        logic [OFS_W-1:0]  port;
        logic [BYTE_W-1:0] data;
    } wr_entry_t;
endpackage

// File: rtl/vdpm_sync.sv
module vdpm_sync #(
    parameter int          WIDTH     = 1,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= RST_VAL;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/vdpm_detect.sv
module vdpm_detect
    import vdpm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_BASE = 8'h98
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] data,
    input  logic              iorq_n,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              m1_n,
    output logic              push,
    output wr_entry_t         entry
);
    typedef struct packed {
        logic      wr_prev;
        logic      push;
        wr_entry_t entry;
    } det_state_t;

    det_state_t st_d, st_q;
    logic       wr_fall;
    logic       is_io_wr;
    logic       in_range;

    always_comb begin
        wr_fall  = st_q.wr_prev && !wr_n;
        is_io_wr = !iorq_n && m1_n && rd_n;
        in_range = (addr[ADDR_W-1:OFS_W] == PORT_BASE[ADDR_W-1:OFS_W]);

        st_d         = st_q;
        st_d.wr_prev = wr_n;
        st_d.push    = wr_fall && is_io_wr && in_range;
        if (wr_fall && is_io_wr && in_range) begin
            st_d.entry.port = addr[OFS_W-1:0];
            st_d.entry.data = data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.wr_prev <= 1'b1;
            st_q.push    <= 1'b0;
            st_q.entry   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign push  = st_q.push;
    assign entry = st_q.entry;
endmodule

// File: rtl/vdpm_fifo.sv
module vdpm_fifo
    import vdpm_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push,
    input  wr_entry_t push_entry,
    output logic      pop_valid,
    input  logic      pop_ready,
    output wr_entry_t pop_entry,
    output logic      full,
    output logic      ovf
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int PTR_W = IDX_W + 1;

    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic             ovf;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    wr_entry_t   mem_q [DEPTH];
    logic        is_empty;
    logic        is_full;
    logic        do_wr;
    logic        do_rd;

    always_comb begin
        is_empty = (st_q.wp == st_q.rp);
        is_full  = (st_q.wp[IDX_W-1:0] == st_q.rp[IDX_W-1:0]) &&
                   (st_q.wp[IDX_W] != st_q.rp[IDX_W]);
        do_wr    = push && !is_full;
        do_rd    = pop_ready && !is_empty;

        st_d = st_q;
        if (do_wr)            st_d.wp  = st_q.wp + 1'b1;
        if (do_rd)            st_d.rp  = st_q.rp + 1'b1;
        if (push && is_full)  st_d.ovf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem_q[st_q.wp[IDX_W-1:0]] <= push_entry;
    end

    assign pop_valid = !is_empty;
    assign pop_entry = mem_q[st_q.rp[IDX_W-1:0]];
    assign full      = is_full;
    assign ovf       = st_q.ovf;
endmodule

// File: rtl/vdp_write_mirror.sv
module vdp_write_mirror
    import vdpm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_BASE   = 8'h98,
    parameter int                FIFO_DEPTH  = 16,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_data,
    input  logic              bus_iorq_n,
    input  logic              bus_wr_n,
    input  logic              bus_rd_n,
    input  logic              bus_m1_n,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [OFS_W-1:0]  out_port,
    output logic [BYTE_W-1:0] out_byte,
    output logic              ovf_flag
);
    localparam int CTL_W = 4;
    localparam int BUS_W = ADDR_W + BYTE_W;

    logic [CTL_W-1:0]  ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              s_iorq_n, s_wr_n, s_rd_n, s_m1_n;
    logic [ADDR_W-1:0] s_addr;
    logic [BYTE_W-1:0] s_data;
    logic              cap_push;
    wr_entry_t         cap_entry;
    wr_entry_t         head_entry;
    logic              fifo_full;

    vdpm_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL({CTL_W{1'b1}})) u_sync_ctl (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_iorq_n, bus_wr_n, bus_rd_n, bus_m1_n}),
        .dout (ctl_s)
    );

    vdpm_sync #(.WIDTH(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_addr, bus_data}),
        .dout (bus_s)
    );

    assign {s_iorq_n, s_wr_n, s_rd_n, s_m1_n} = ctl_s;
    assign {s_addr, s_data}                   = bus_s;

    vdpm_detect #(.PORT_BASE(PORT_BASE)) u_detect (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (s_addr),
        .data  (s_data),
        .iorq_n(s_iorq_n),
        .wr_n  (s_wr_n),
        .rd_n  (s_rd_n),
        .m1_n  (s_m1_n),
        .push  (cap_push),
        .entry (cap_entry)
    );

    vdpm_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (cap_push),
        .push_entry(cap_entry),
        .pop_valid (out_valid),
        .pop_ready (out_ready),
        .pop_entry (head_entry),
        .full      (fifo_full),
        .ovf       (ovf_flag)
    );

    assign out_port = head_entry.port;
    assign out_byte = head_entry.data;
endmodule

// File: rtl/vdpm_checker.sv
module vdpm_checker
    import vdpm_pkg::*;
#(
    parameter logic [ADDR_W-1:0] PORT_BASE = 8'h98
) (
    input logic              clk,
    input logic              rst_n,
    input logic              out_valid,
    input logic              out_ready,
    input logic [OFS_W-1:0]  out_port,
    input logic [BYTE_W-1:0] out_byte,
    input logic              ovf_flag,
    input logic              cap_push,
    input logic              s_iorq_n,
    input logic              s_m1_n,
    input logic              s_rd_n,
    input logic [ADDR_W-1:0] s_addr,
    input logic              fifo_full
);
    // R10: the head entry is held while the consumer stalls
    a_r10_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port) && $stable(out_byte)));

    // R8: the flag never clears without a reset
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    // R8: the flag rises only after a capture into a full queue
    a_r8_ovf_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> ($past(cap_push) && $past(fifo_full)));

    // R5: no capture comes from an acknowledge cycle
    a_r5_no_ack_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> ($past(s_m1_n) && !$past(s_iorq_n)));

    // R4: no capture while the read strobe is active
    a_r4_no_read_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> $past(s_rd_n));

    // R3: every capture was aimed at the watched range
    a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |-> ($past(s_addr[ADDR_W-1:OFS_W]) == PORT_BASE[ADDR_W-1:OFS_W]));

    // R9: captures are single pulses
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cap_push |=> !cap_push);
endmodule

bind vdp_write_mirror vdpm_checker #(.PORT_BASE(PORT_BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_port (out_port),
    .out_byte (out_byte),
    .ovf_flag (ovf_flag),
    .cap_push (cap_push),
    .s_iorq_n (s_iorq_n),
    .s_m1_n   (s_m1_n),
    .s_rd_n   (s_rd_n),
    .s_addr   (s_addr),
    .fifo_full(fifo_full)
);

// File: tb/vdp_write_mirror_bench.sv
module vdp_write_mirror_bench;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_data = '0;
    logic       bus_iorq_n = 1'b1;
    logic       bus_wr_n = 1'b1;
    logic       bus_rd_n = 1'b1;
    logic       bus_m1_n = 1'b1;
    logic       out_valid;
    logic       out_ready = 1'b0;
    logic [1:0] out_port;
    logic [7:0] out_byte;
    logic       ovf_flag;

    int total = 0;
    int bad   = 0;
    int cycles = 0;
    bit done = 1'b0;

    vdp_write_mirror u_vdp_write_mirror (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_data(bus_data),
        .bus_iorq_n(bus_iorq_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_m1_n(bus_m1_n),
        .out_valid(out_valid), .out_ready(out_ready),
        .out_port(out_port), .out_byte(out_byte),
        .ovf_flag(ovf_flag)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // generic bus cycle: strobes asserted for hold cycles
    task automatic bus_cycle(input logic [7:0] a, input logic [7:0] d,
                             input logic iorq_n, input logic m1_n,
                             input logic rd_n, input logic wr_n, input int hold);
        @(negedge clk);
        bus_addr = a; bus_data = d; bus_iorq_n = iorq_n; bus_m1_n = m1_n;
        idle(3);
        bus_rd_n = rd_n; bus_wr_n = wr_n;
        idle(hold);
        bus_rd_n = 1'b1; bus_wr_n = 1'b1;
        idle(2);
        bus_iorq_n = 1'b1; bus_m1_n = 1'b1;
        idle(6);
    endtask

    task automatic io_write(input logic [7:0] a, input logic [7:0] d);
        bus_cycle(a, d, 1'b0, 1'b1, 1'b1, 1'b0, 6);
    endtask

    task automatic pop_one();
        @(negedge clk); out_ready = 1'b1;
        @(negedge clk); out_ready = 1'b0;
    endtask

    initial begin
        idle(3);
        check(!out_valid, "R1 valid after reset", out_valid, 0);
        check(!ovf_flag,  "R1 ovf after reset", ovf_flag, 0);
        @(negedge clk); rst_n = 1'b1;
        idle(3);
        check(!out_valid, "R1 valid idle", out_valid, 0);

        // R2/R3 sweep of every I/O address
        for (int a = 0; a < 256; a++) begin
            logic [7:0] d;
            bit hit;
            d = 8'(a) ^ 8'h5A;
            hit = (a >= 8'h98) && (a <= 8'h9B);
            io_write(8'(a), d);
            if (hit) begin
                check(out_valid, "R2 entry present", out_valid, 1);
                check(out_port == 2'(a), "R2 port offset", out_port, a & 3);
                check(out_byte == d, "R2 data byte", out_byte, d);
                pop_one();
                idle(1);
                check(!out_valid, "R2 single entry", out_valid, 0);
            end else begin
                check(!out_valid, "R3 out of range ignored", out_valid, 0);
            end
        end

        // R4 reads, R5 acknowledge, R6 memory writes
        for (int p = 0; p < 4; p++) begin
            bus_cycle(8'h98 + 8'(p), 8'hC3, 1'b0, 1'b1, 1'b0, 1'b1, 6);
            check(!out_valid, "R4 read ignored", out_valid, 0);
            bus_cycle(8'h98 + 8'(p), 8'h3C, 1'b0, 1'b0, 1'b1, 1'b0, 6);
            check(!out_valid, "R5 acknowledge ignored", out_valid, 0);
            bus_cycle(8'h98 + 8'(p), 8'h77, 1'b1, 1'b1, 1'b1, 1'b0, 6);
            check(!out_valid, "R6 memory write ignored", out_valid, 0);
        end

        // R9 long-held strobe
        bus_cycle(8'h99, 8'hA5, 1'b0, 1'b1, 1'b1, 1'b0, 60);
        check(out_valid && out_byte == 8'hA5, "R9 held strobe entry", out_byte, 8'hA5);
        pop_one(); idle(1);
        check(!out_valid, "R9 one entry per edge", out_valid, 0);

        // R7/R8/R10 fill past capacity
        for (int i = 0; i < 17; i++) begin
            io_write(8'h98 + 8'(i % 4), 8'(i * 7 + 1));
            if (i == 15) check(!ovf_flag, "R8 no flag at 16", ovf_flag, 0);
        end
        check(ovf_flag, "R8 flag on 17th write", ovf_flag, 1);
        begin
            logic [7:0] b0;
            b0 = out_byte;
            idle(5);
            check(out_valid && out_byte == b0, "R10 held while stalled", out_byte, b0);
        end
        for (int i = 0; i < 16; i++) begin
            check(out_valid, "R7 entry queued", out_valid, 1);
            check(out_port == 2'(i % 4), "R7 order port", out_port, i % 4);
            check(out_byte == 8'(i * 7 + 1), "R8 kept entry", out_byte, (i * 7 + 1) & 8'hFF);
            pop_one();
        end
        idle(1);
        check(!out_valid, "R8 dropped write absent", out_valid, 0);
        check(ovf_flag, "R8 flag sticky", ovf_flag, 1);

        // R7 back-to-back pops with ready held high
        for (int i = 0; i < 3; i++) io_write(8'h9A, 8'(8'hE0 + i));
        @(negedge clk); out_ready = 1'b1;
        @(negedge clk); check(out_byte == 8'hE1, "R7 second entry", out_byte, 8'hE1);
        @(negedge clk); check(out_byte == 8'hE2, "R7 third entry", out_byte, 8'hE2);
        @(negedge clk); out_ready = 1'b0;
        check(!out_valid, "R7 drained", out_valid, 0);

        // R1 reset clears the flag
        rst_n = 1'b0; idle(2);
        check(!ovf_flag, "R1 flag cleared by reset", ovf_flag, 0);
        rst_n = 1'b1; idle(2);
        done = 1'b1;
    end

    initial begin
        while (!done && cycles < WATCHDOG) begin
            @(posedge clk);
            cycles++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule